// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

The block lets two processors, side A and side B, trade 32-bit words and raise attention signals at each other while each runs on its own unrelated bus clock. Each side sees the same small register window: a set of outgoing data slots, a set of incoming data slots, a control word, a status word and a doorbell register. It also has a single interrupt line. A word written into an outgoing slot on one side shows up in the matching incoming slot on the other side. When the peer consumes it, the writer gets a transmit-empty event back.

Flags cross between the clock domains as toggles through a two-flop synchronizer, with an edge detector in the receiving domain. The 32-bit data is not synchronized. The sender's slot cannot change between the write and the acknowledgement, so the receiver samples a stable value. Doorbells carry no data. The sender's bit stays pending until the peer clears its incoming bit by writing one to it, and that clear travels back as an acknowledgement. Each side can also raise a reset request, which the peer sees as a status bit and an optional interrupt. Both sides are expected to leave reset together.

Top module: `mbx_dual_clock`

## Requirements
- R1: After reset, status (address 9) and control (address 8) read as zero on both sides, and both interrupt outputs are low.
- R2: Writing outgoing slot i (address i, i = 0..3) sets the sender's busy bit (status bit i). After the peer has read the word, busy clears and the transmit-empty event (status bit 12+i) sets.
- R3: A word sent on channel i sets the peer's receive-full bit (status bit 4+i) within a few cycles. Reading incoming slot i (address 4+i) returns the word and clears that bit.
- R4: A write to an outgoing slot whose busy bit is set is ignored. The peer receives the first word.
- R5: Reading an incoming slot that is not full returns the last word held there and changes no status bit.
- R6: Writing one to bit j of the doorbell register (address 10) sets the peer's incoming doorbell bit (status bit 8+j) and the sender's pending bit (status bit 16+j). The pending bit stays set until the peer writes one to its status bit 8+j.
- R7: Ringing a doorbell whose pending bit is set has no effect. No second incoming doorbell appears after the peer clears the first.
- R8: Transmit-empty event bits clear only when one is written to them at the status address. Writing zero leaves them set.
- R9: The interrupt is the OR of the enabled sources. Control bits 0..3 enable transmit-empty events, bits 4..7 enable receive-full, bits 8..11 enable incoming doorbells, and bit 12 enables the peer reset request. With all enables clear, the interrupt stays low.
- R10: Control bit 13 is the side's reset request. The peer sees it as status bit 20 after synchronization, and the bit drops when the request is withdrawn.
- R11: Both directions behave identically, side B to side A as well as A to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A bus clock |
| rst_a_n | input | 1 | Side A synchronous active-low reset |
| a_addr | input | 4 | Side A register word address |
| a_wdata | input | 32 | Side A write data |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data, registered, valid the cycle after the strobe |
| a_irq | output | 1 | Side A combined interrupt |
| clk_b | input | 1 | Side B bus clock |
| rst_b_n | input | 1 | Side B synchronous active-low reset |
| b_addr | input | 4 | Side B register word address |
| b_wdata | input | 32 | Side B write data |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data, registered, valid the cycle after the strobe |
| b_irq | output | 1 | Side B combined interrupt |

## Verification
The assertions watch the sender-side rules on every cycle in both clock domains. Outgoing data stays frozen while a slot is busy. A send or ring toggle fires only from an idle slot and leaves it busy. At most one channel fires per cycle, and the interrupt is low right after reset. The end-to-end behaviour involves both domains and software actions, so only the bench scenarios can show it. That covers delivery of the word, the acknowledgement returning as a transmit-empty event, doorbell pending lasting until the peer clears it, the write-one-to-clear rules, the interrupt masking and the reset request reaching the peer.

// File: rtl/mbx_pkg.sv
// Package: shared sizes, register addresses and bit positions for the mailbox.
// Assumes four channels per kind; all positions derive from NCH.
package mbx_pkg;
    localparam int NCH = 4;            // channels per kind and direction
    localparam int DW  = 32;           // data word width
    localparam int AW  = 4;            // register word address width
    localparam int IW  = $clog2(NCH);  // channel index width

    // register word addresses
    localparam int ADDR_TX   = 0;       // outgoing slots ADDR_TX .. +NCH-1
    localparam int ADDR_RX   = NCH;     // incoming slots
    localparam int ADDR_CTRL = 2 * NCH;
    localparam int ADDR_STAT = 2 * NCH + 1;
    localparam int ADDR_RING = 2 * NCH + 2;

    // status word fields
    localparam int ST_TXBUSY = 0;
    localparam int ST_RXFULL = NCH;
    localparam int ST_DBIN   = 2 * NCH;
    localparam int ST_TXE    = 3 * NCH;
    localparam int ST_DBOUT  = 4 * NCH;
    localparam int ST_PRST   = 5 * NCH;
    localparam int ST_W      = 5 * NCH + 1;

    // control word fields
    localparam int CT_TXE_EN = 0;
    localparam int CT_RXF_EN = NCH;
    localparam int CT_DB_EN  = 2 * NCH;
    localparam int CT_RST_EN = 3 * NCH;
    localparam int CT_RSTREQ = 3 * NCH + 1;
    localparam int CTRL_W    = 3 * NCH + 2;

    // bundle of toggles and levels arriving from the peer
    localparam int XIN_W = 4 * NCH + 1;
endpackage

// File: rtl/mbx_sync.sv
// Module: two-flop synchronizer for a bundle of slowly changing bits.
// Assumes each bit is a level or toggle held for several destination cycles.
module mbx_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // capture the asynchronous bundle and resolve it over two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mbx_side.sv
// Module: one side's register window, flags and interrupt for the mailbox.
// Assumes the peer's outgoing data holds still while this side's receive
// flag is set, so that data is read without synchronization.
module mbx_side
    import mbx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   wr,
    input  logic                   rd,
    output logic [DW-1:0]          rdata,
    output logic                   irq,
    output logic [NCH-1:0]         tx_tgl,
    output logic [NCH-1:0][DW-1:0] tx_data,
    output logic [NCH-1:0]         rxack_tgl,
    output logic [NCH-1:0]         db_tgl,
    output logic [NCH-1:0]         dback_tgl,
    output logic                   rst_req,
    output logic [2*NCH-1:0]       busy,
    input  logic [NCH-1:0]         peer_tx_tgl,
    input  logic [NCH-1:0][DW-1:0] peer_tx_data,
    input  logic [NCH-1:0]         peer_rxack_tgl,
    input  logic [NCH-1:0]         peer_db_tgl,
    input  logic [NCH-1:0]         peer_dback_tgl,
    input  logic                   peer_rst
);
    localparam logic [AW-1:0] A_TX   = AW'(ADDR_TX);
    localparam logic [AW-1:0] A_RX   = AW'(ADDR_RX);
    localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);
    localparam logic [AW-1:0] A_RING = AW'(ADDR_RING);
    localparam int            TG_W   = XIN_W - 1;

    logic [XIN_W-1:0]  xin_q;
    logic [TG_W-1:0]   seen_q;
    logic [TG_W-1:0]   chg;
    logic [NCH-1:0]    rx_chg, ack_chg, db_chg, dback_chg;
    logic [NCH-1:0]    tx_busy, txe_ev, rx_full, db_in, db_out;
    logic [NCH-1:0]    wr_tx, rd_rx, ring, w1c_txe, db_clr;
    logic [CTRL_W-1:0] ctrl;
    logic [ST_W-1:0]   status;
    logic              wr_stat, rx_hit;
    logic [IW-1:0]     rx_idx;

    mbx_sync #(.W(XIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({peer_rst, peer_dback_tgl, peer_db_tgl, peer_rxack_tgl, peer_tx_tgl}),
        .q     (xin_q)
    );

    // remember synchronized toggles so each change yields a one-cycle event
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= xin_q[TG_W-1:0];
    end

    assign chg       = xin_q[TG_W-1:0] ^ seen_q;
    assign rx_chg    = chg[0*NCH +: NCH];
    assign ack_chg   = chg[1*NCH +: NCH];
    assign db_chg    = chg[2*NCH +: NCH];
    assign dback_chg = chg[3*NCH +: NCH];

    // decode bus strobes into per-channel actions, gated by slot state
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            wr_tx[i] = wr && (addr == A_TX + AW'(i)) && !tx_busy[i];
            rd_rx[i] = rd && (addr == A_RX + AW'(i)) && rx_full[i];
        end
        wr_stat = wr && (addr == A_STAT);
        ring    = (wr && addr == A_RING) ? (wdata[NCH-1:0] & ~db_out) : '0;
        w1c_txe = wr_stat ? wdata[ST_TXE +: NCH] : '0;
        db_clr  = wr_stat ? (wdata[ST_DBIN +: NCH] & db_in) : '0;
        rx_hit  = (addr >= A_RX) && (addr < A_RX + AW'(NCH));
        rx_idx  = IW'(addr - A_RX);
    end

    // channel flags, toggles and outgoing data slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_busy   <= '0;
            tx_tgl    <= '0;
            tx_data   <= '0;
            txe_ev    <= '0;
            rx_full   <= '0;
            rxack_tgl <= '0;
            db_out    <= '0;
            db_tgl    <= '0;
            db_in     <= '0;
            dback_tgl <= '0;
        end else begin
            tx_busy   <= (tx_busy | wr_tx) & ~ack_chg;
            tx_tgl    <= tx_tgl ^ wr_tx;
            txe_ev    <= (txe_ev & ~w1c_txe) | ack_chg;
            rx_full   <= (rx_full | rx_chg) & ~rd_rx;
            rxack_tgl <= rxack_tgl ^ rd_rx;
            db_out    <= (db_out | ring) & ~dback_chg;
            db_tgl    <= db_tgl ^ ring;
            db_in     <= (db_in | db_chg) & ~db_clr;
            dback_tgl <= dback_tgl ^ db_clr;
            for (int i = 0; i < NCH; i++) begin
                if (wr_tx[i]) tx_data[i] <= wdata;
            end
        end
    end

    // control word: interrupt enables and the reset request
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctrl <= '0;
        else if (wr && addr == A_CTRL) ctrl <= wdata[CTRL_W-1:0];
    end

    assign status = {xin_q[TG_W], db_out, txe_ev, db_in, rx_full, tx_busy};

    // registered read data, valid the cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata <= '0;
        else if (rd) begin
            if (rx_hit)              rdata <= peer_tx_data[rx_idx];
            else if (addr == A_CTRL) rdata <= DW'(ctrl);
            else if (addr == A_STAT) rdata <= DW'(status);
            else                     rdata <= '0;
        end
    end

    assign irq = |(txe_ev  & ctrl[CT_TXE_EN +: NCH])
               | |(rx_full & ctrl[CT_RXF_EN +: NCH])
               | |(db_in   & ctrl[CT_DB_EN  +: NCH])
               | (xin_q[TG_W] & ctrl[CT_RST_EN]);
    assign rst_req = ctrl[CT_RSTREQ];
    assign busy    = {db_out, tx_busy};
endmodule

// File: rtl/mbx_dual_clock.sv
// Module: top of the two-sided mailbox; wires two mirrored sides together.
// Assumes both sides are reset together before any traffic.
module mbx_dual_clock
    import mbx_pkg::*;
(
    input  logic          clk_a,
    input  logic          rst_a_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_wr,
    input  logic          a_rd,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_wr,
    input  logic          b_rd,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NCH-1:0]         a_tx_tgl, a_rxack_tgl, a_db_tgl, a_dback_tgl;
    logic [NCH-1:0]         b_tx_tgl, b_rxack_tgl, b_db_tgl, b_dback_tgl;
    logic [NCH-1:0][DW-1:0] a_tx_data, b_tx_data;
    logic [2*NCH-1:0]       a_busy, b_busy;
    logic                   a_rst_req, b_rst_req;

    mbx_side u_side_a (
        .clk (clk_a), .rst_n (rst_a_n),
        .addr (a_addr), .wdata (a_wdata), .wr (a_wr), .rd (a_rd),
        .rdata (a_rdata), .irq (a_irq),
        .tx_tgl (a_tx_tgl), .tx_data (a_tx_data), .rxack_tgl (a_rxack_tgl),
        .db_tgl (a_db_tgl), .dback_tgl (a_dback_tgl), .rst_req (a_rst_req),
        .busy (a_busy),
        .peer_tx_tgl (b_tx_tgl), .peer_tx_data (b_tx_data),
        .peer_rxack_tgl (b_rxack_tgl), .peer_db_tgl (b_db_tgl),
        .peer_dback_tgl (b_dback_tgl), .peer_rst (b_rst_req)
    );

    mbx_side u_side_b (
        .clk (clk_b), .rst_n (rst_b_n),
        .addr (b_addr), .wdata (b_wdata), .wr (b_wr), .rd (b_rd),
        .rdata (b_rdata), .irq (b_irq),
        .tx_tgl (b_tx_tgl), .tx_data (b_tx_data), .rxack_tgl (b_rxack_tgl),
        .db_tgl (b_db_tgl), .dback_tgl (b_dback_tgl), .rst_req (b_rst_req),
        .busy (b_busy),
        .peer_tx_tgl (a_tx_tgl), .peer_tx_data (a_tx_data),
        .peer_rxack_tgl (a_rxack_tgl), .peer_db_tgl (a_db_tgl),
        .peer_dback_tgl (a_dback_tgl), .peer_rst (a_rst_req)
    );
endmodule

// File: rtl/mbx_checker.sv
// Module: sender-side protocol checks for both clock domains of the mailbox.
// Assumes it is bound to mbx_dual_clock and sees its crossing signals.
module mbx_checker
    import mbx_pkg::*;
(
    input logic                   clk_a,
    input logic                   rst_a_n,
    input logic [NCH-1:0]         a_tx_tgl,
    input logic [NCH-1:0][DW-1:0] a_tx_data,
    input logic [NCH-1:0]         a_db_tgl,
    input logic [2*NCH-1:0]       a_busy,
    input logic                   a_irq,
    input logic                   clk_b,
    input logic                   rst_b_n,
    input logic [NCH-1:0]         b_tx_tgl,
    input logic [NCH-1:0][DW-1:0] b_tx_data,
    input logic [NCH-1:0]         b_db_tgl,
    input logic [2*NCH-1:0]       b_busy,
    input logic                   b_irq
);
    assert_irq_quiet_a_R1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $past(!rst_a_n) |-> !a_irq);
    assert_irq_quiet_b_R1: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $past(!rst_b_n) |-> !b_irq);
    assert_one_send_a_R2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $onehot0(a_tx_tgl ^ $past(a_tx_tgl)));
    assert_one_send_b_R2: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $onehot0(b_tx_tgl ^ $past(b_tx_tgl)));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assert_data_hold_a_R4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (a_busy[i] && $past(a_busy[i])) |-> $stable(a_tx_data[i]));
        assert_data_hold_b_R4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
            (b_busy[i] && $past(b_busy[i])) |-> $stable(b_tx_data[i]));
        assert_send_from_idle_a_R4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (a_tx_tgl[i] != $past(a_tx_tgl[i])) |-> (!$past(a_busy[i]) && a_busy[i]));
        assert_send_from_idle_b_R11: assert property (@(posedge clk_b) disable iff (!rst_b_n)
            (b_tx_tgl[i] != $past(b_tx_tgl[i])) |-> (!$past(b_busy[i]) && b_busy[i]));
        assert_ring_from_idle_a_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (a_db_tgl[i] != $past(a_db_tgl[i])) |-> (!$past(a_busy[NCH+i]) && a_busy[NCH+i]));
        assert_ring_from_idle_b_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
            (b_db_tgl[i] != $past(b_db_tgl[i])) |-> (!$past(b_busy[NCH+i]) && b_busy[NCH+i]));
    end
endmodule

bind mbx_dual_clock mbx_checker u_chk (
    .clk_a (clk_a), .rst_a_n (rst_a_n), .a_tx_tgl (a_tx_tgl), .a_tx_data (a_tx_data),
    .a_db_tgl (a_db_tgl), .a_busy (a_busy), .a_irq (a_irq),
    .clk_b (clk_b), .rst_b_n (rst_b_n), .b_tx_tgl (b_tx_tgl), .b_tx_data (b_tx_data),
    .b_db_tgl (b_db_tgl), .b_busy (b_busy), .b_irq (b_irq)
);

// File: tb/test_mbx_dual_clock.sv
// Bench: directed corner cases plus seeded random transfers in both directions.
module test_mbx_dual_clock;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_B_PER  = CLK_PERIOD + 4;
    localparam int WDOG_LIMIT = 150000;

    logic        clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
    logic [3:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;
    int          checks = 0, failures = 0, cyc = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk_a = ~clk_a;
    always #(CLK_B_PER/2)  clk_b = ~clk_b;

    mbx_dual_clock i_mbx_dual_clock (
        .clk_a (clk_a), .rst_a_n (rst_a_n), .a_addr (a_addr), .a_wdata (a_wdata),
        .a_wr (a_wr), .a_rd (a_rd), .a_rdata (a_rdata), .a_irq (a_irq),
        .clk_b (clk_b), .rst_b_n (rst_b_n), .b_addr (b_addr), .b_wdata (b_wdata),
        .b_wr (b_wr), .b_rd (b_rd), .b_rdata (b_rdata), .b_irq (b_irq)
    );

    function automatic logic [31:0] bitv(input int pos);
        return 32'd1 << pos;
    endfunction

    function automatic logic [31:0] fld(input logic [31:0] w, input int pos);
        return (w >> pos) & 32'd1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input bit sb, input logic [3:0] ad, input logic [31:0] d);
        if (!sb) begin
            @(negedge clk_a); a_addr = ad; a_wdata = d; a_wr = 1;
            @(negedge clk_a); a_wr = 0;
        end else begin
            @(negedge clk_b); b_addr = ad; b_wdata = d; b_wr = 1;
            @(negedge clk_b); b_wr = 0;
        end
    endtask

    task automatic bus_rd(input bit sb, input logic [3:0] ad, output logic [31:0] d);
        if (!sb) begin
            @(negedge clk_a); a_addr = ad; a_rd = 1;
            @(negedge clk_a); a_rd = 0; d = a_rdata;
        end else begin
            @(negedge clk_b); b_addr = ad; b_rd = 1;
            @(negedge clk_b); b_rd = 0; d = b_rdata;
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge clk_a);
        repeat (8) @(posedge clk_b);
        @(negedge clk_a);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as a failed check
    always @(posedge clk_a) begin
        cyc++;
        if (cyc == WDOG_LIMIT && !done) begin
            checks++; failures++;
            $display("FAIL watchdog R1..all actual=%0d expected<%0d", cyc, WDOG_LIMIT);
            summary();
        end
    end

    initial begin
        logic [31:0] r, d1, d2;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk_b);
        @(negedge clk_a); rst_a_n = 1; rst_b_n = 1;

        // R1: reset state
        bus_rd(0, 4'd9, r); chk("R1 stat A", r, 0);
        bus_rd(1, 4'd9, r); chk("R1 stat B", r, 0);
        bus_rd(0, 4'd8, r); chk("R1 ctrl A", r, 0);
        chk("R1 irq", {30'b0, a_irq, b_irq}, 0);

        // R2, R3: one word A -> B
        bus_wr(0, 4'd0, 32'hCAFE_0001);
        bus_rd(0, 4'd9, r); chk("R2 busy set", fld(r, 0), 1);
        settle();
        bus_rd(1, 4'd9, r); chk("R3 rx full", fld(r, 4), 1);
        bus_rd(1, 4'd4, r); chk("R3 rx data", r, 32'hCAFE_0001);
        bus_rd(1, 4'd9, r); chk("R3 rx cleared", fld(r, 4), 0);
        settle();
        bus_rd(0, 4'd9, r); chk("R2 busy clear", fld(r, 0), 0);
        chk("R2 txe event", fld(r, 12), 1);

        // R8: write-one-to-clear of transmit-empty events
        bus_wr(0, 4'd9, 32'h0);
        bus_rd(0, 4'd9, r); chk("R8 zero keeps", fld(r, 12), 1);
        bus_wr(0, 4'd9, bitv(12));
        bus_rd(0, 4'd9, r); chk("R8 one clears", fld(r, 12), 0);

        // R4, R5: write to busy slot ignored; read of empty slot
        bus_wr(0, 4'd1, 32'h1111_1111);
        bus_wr(0, 4'd1, 32'h2222_2222);
        settle();
        bus_rd(1, 4'd5, r); chk("R4 first word kept", r, 32'h1111_1111);
        settle();
        bus_rd(1, 4'd5, r); chk("R5 empty read value", r, 32'h1111_1111);
        bus_rd(1, 4'd9, r); chk("R5 status unchanged", r, 0);

        // R11 and R4: seeded random traffic in both directions
        for (int n = 0; n < 40; n++) begin
            bit sb = 1'($urandom % 2);
            int ch = int'($urandom % 4);
            d1 = $urandom; d2 = $urandom;
            bus_wr(sb, 4'(ch), d1);
            if ($urandom % 3 == 0) bus_wr(sb, 4'(ch), d2);
            settle();
            bus_rd(!sb, 4'(4 + ch), r);
            chk(sb ? "R11 B to A data" : "R3 A to B data", r, d1);
            settle();
            bus_rd(sb, 4'd9, r);
            chk("R2 random busy clear", fld(r, ch), 0);
            chk("R2 random txe", fld(r, 12 + ch), 1);
            bus_wr(sb, 4'd9, 32'h0000_F000);
        end

        // R6, R7: doorbell with software acknowledge
        bus_wr(0, 4'd10, bitv(2));
        settle();
        bus_rd(1, 4'd9, r); chk("R6 peer doorbell", fld(r, 10), 1);
        bus_rd(0, 4'd9, r); chk("R6 sender pending", fld(r, 18), 1);
        settle();
        bus_rd(0, 4'd9, r); chk("R6 still pending", fld(r, 18), 1);
        bus_wr(0, 4'd10, bitv(2));
        bus_wr(1, 4'd9, bitv(10));
        settle();
        bus_rd(0, 4'd9, r); chk("R6 pending released", fld(r, 18), 0);
        settle();
        bus_rd(1, 4'd9, r); chk("R7 no second ring", fld(r, 10), 0);

        // R9: interrupt masking
        bus_wr(0, 4'd2, 32'hABCD_0002);
        settle();
        chk("R9 masked rx", {31'b0, b_irq}, 0);
        bus_wr(1, 4'd8, bitv(6));
        chk("R9 rx enabled", {31'b0, b_irq}, 1);
        bus_rd(1, 4'd6, r);
        @(negedge clk_b);
        chk("R9 rx consumed", {31'b0, b_irq}, 0);
        settle();
        chk("R9 masked txe", {31'b0, a_irq}, 0);
        bus_wr(0, 4'd8, bitv(2));
        chk("R9 txe enabled", {31'b0, a_irq}, 1);
        bus_wr(0, 4'd9, bitv(14));
        chk("R9 txe cleared", {31'b0, a_irq}, 0);
        bus_wr(1, 4'd8, bitv(9));
        bus_wr(0, 4'd10, bitv(1));
        settle();
        chk("R9 doorbell irq", {31'b0, b_irq}, 1);
        bus_wr(1, 4'd9, bitv(9));
        @(negedge clk_b);
        chk("R9 doorbell acked", {31'b0, b_irq}, 0);

        // R10: reset request reaches the peer
        bus_wr(0, 4'd8, bitv(13));
        bus_wr(1, 4'd8, bitv(12));
        settle();
        bus_rd(1, 4'd9, r); chk("R10 peer sees request", fld(r, 20), 1);
        chk("R10 peer irq", {31'b0, b_irq}, 1);
        bus_wr(0, 4'd8, 32'h0);
        settle();
        bus_rd(1, 4'd9, r); chk("R10 request withdrawn", fld(r, 20), 0);
        chk("R10 irq dropped", {31'b0, b_irq}, 0);

        summary();
    end
endmodule